// File: doc/BRIEF.md
# Instruction Spatial Region Compactor

This block watches the addresses of retired instructions and folds them into region records. A record names one trigger block, meaning the cache block of the address that opened the region. Around the trigger it keeps two bitmaps. The behind map covers PREC_N blocks below the trigger and the ahead map covers SUCC_N blocks above it. Retired addresses that land inside the window set their bit. The first address that lands outside the window closes the open record and opens a new region on that address's block.

Closed records go through a small recency store of DEPTH entries before they leave the block. If a closed record equals one already held there (same trigger and same bitmaps), that entry becomes the most recent one and nothing is emitted. Any other record goes in at the most recent position, pushes out the least recent entry, and is offered downstream through a single valid/ready register. A combinational query port reports whether an address is covered by the open region or by any record held in the recency store. A downstream prefetch engine can use this to test whether a fetch target has already been recorded.

Top module: `region_compactor`

## Requirements
- R1: After reset no region is open, `outValid` is 0, `retReady` is 1 and `qryHit` is 0 for every query.
- R2: While no region is open, an accepted retirement opens a region with its block (`addr >> BLK_LOG`) as trigger and emits nothing.
- R3: For an accepted retirement, let d be its block minus the open trigger. If d is in [-PREC_N, -1], behind bit (-d-1) is set. If d is in [1, SUCC_N], ahead bit (d-1) is set. If d is 0, the record does not change. No trigger or bit is ever cleared while the region stays open.
- R4: An accepted retirement outside the window closes the open record. A new region then opens with that block as trigger and both bitmaps cleared.
- R5: A closed record equal in trigger and both bitmaps to a valid stored entry moves that entry to the most recent position and is not emitted.
- R6: Any other closed record is stored at the most recent position, and the least recent entry is dropped when all DEPTH entries are valid. One cycle after closing, the record appears on `outValid`/`outTrigger`/`outPrec`/`outSucc`.
- R7: `retReady` equals `!outValid || outReady`. While `outValid` is 1 and `outReady` is 0, the output record holds steady. A cycle with `outValid` and `outReady` both 1 consumes it.
- R8: `qryHit` is 1 exactly when the query block is the trigger of the open region or of a valid stored entry, or is at a set bit position of one of them under the mapping of R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| retValid | input | 1 | A retired instruction address is offered |
| retAddr | input | ADDR_W | Retired instruction byte address |
| retReady | output | 1 | Retirement is accepted this cycle |
| qryAddr | input | ADDR_W | Address to test for coverage |
| qryHit | output | 1 | Query address is covered by a record |
| outValid | output | 1 | A new region record is offered |
| outReady | input | 1 | Downstream takes the record |
| outTrigger | output | ADDR_W-BLK_LOG | Trigger block of the offered record |
| outPrec | output | PREC_N | Behind bitmap, bit i is trigger minus (i+1) |
| outSucc | output | SUCC_N | Ahead bitmap, bit i is trigger plus (i+1) |

## Verification
The assertions rely on every input being a known value after reset and on `retAddr` mattering only in cycles where `retValid` and `retReady` are both high. They also assume block distances are taken modulo the block-address width. An address near the top of the space could therefore see the bottom of the space as a neighbour. The bench keeps every input defined in every cycle, and it draws addresses from a few bases well away from both ends of the address space. It toggles `outReady` at random so that backpressure occurs both while records are pending and while none are.

// File: rtl/rc_pkg.sv
package rc_pkg;
  // Strobes from the control block to the datapath, one per action
  typedef struct packed {
    logic openFirst;   // first region after reset
    logic setBit;      // address lands inside the open window
    logic rollRegion;  // address lands outside: close and reopen
    logic promote;     // closed record already stored
    logic insert;      // closed record is new
    logic popOut;      // output record consumed
  } rcStrobe_t;
endpackage

// File: rtl/rc_cover.sv
// Places one block relative to a record and reports window and coverage
module rc_cover #(
  parameter int BLK_W  = 26,
  parameter int PREC_N = 4,
  parameter int SUCC_N = 8
) (
  input  logic              valid,
  input  logic [BLK_W-1:0]  trig,
  input  logic [PREC_N-1:0] precBits,
  input  logic [SUCC_N-1:0] succBits,
  input  logic [BLK_W-1:0]  blk,
  output logic              inWin,
  output logic              hit,
  output logic [PREC_N-1:0] precPos,
  output logic [SUCC_N-1:0] succPos
);
  logic [BLK_W-1:0] fwd, back;
  logic isTrig;

  always_comb begin
    fwd    = blk - trig;
    back   = trig - blk;
    isTrig = (fwd == '0);
    for (int i = 0; i < PREC_N; i++) precPos[i] = (back == BLK_W'(i + 1));
    for (int i = 0; i < SUCC_N; i++) succPos[i] = (fwd == BLK_W'(i + 1));
    inWin = valid && (isTrig || (|precPos) || (|succPos));
    hit   = valid && (isTrig || (|(precPos & precBits)) || (|(succPos & succBits)));
  end
endmodule

// File: rtl/rc_ctrl.sv
module rc_ctrl
  import rc_pkg::*;
(
  input  logic      retValid,
  input  logic      outReady,
  input  logic      regionOpen,
  input  logic      inRegion,
  input  logic      tempMatch,
  input  logic      outValid,
  output logic      retReady,
  output rcStrobe_t strb
);
  logic fire;

  always_comb begin
    retReady        = !outValid || outReady;
    fire            = retValid && retReady;
    strb.openFirst  = fire && !regionOpen;
    strb.setBit     = fire && regionOpen && inRegion;
    strb.rollRegion = fire && regionOpen && !inRegion;
    strb.promote    = strb.rollRegion && tempMatch;
    strb.insert     = strb.rollRegion && !tempMatch;
    strb.popOut     = outValid && outReady;
  end
endmodule

// File: rtl/rc_spatial.sv
// Open region register: trigger plus behind/ahead bitmaps
module rc_spatial
  import rc_pkg::*;
#(
  parameter int BLK_W  = 26,
  parameter int PREC_N = 4,
  parameter int SUCC_N = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  rcStrobe_t         strb,
  input  logic [BLK_W-1:0]  retBlk,
  input  logic [BLK_W-1:0]  qryBlk,
  output logic              regionOpen,
  output logic              inRegion,
  output logic [BLK_W-1:0]  curTrig,
  output logic [PREC_N-1:0] curPrec,
  output logic [SUCC_N-1:0] curSucc,
  output logic              qryHitS
);
  logic [PREC_N-1:0] retPrecPos, unusedQryPrec;
  logic [SUCC_N-1:0] retSuccPos, unusedQrySucc;
  logic unusedRetHit, unusedQryWin, unusedStrb;

  assign unusedStrb = strb.promote ^ strb.insert ^ strb.popOut;

  rc_cover #(.BLK_W(BLK_W), .PREC_N(PREC_N), .SUCC_N(SUCC_N)) uRetPlace (
    .valid(regionOpen), .trig(curTrig), .precBits(curPrec), .succBits(curSucc),
    .blk(retBlk), .inWin(inRegion), .hit(unusedRetHit),
    .precPos(retPrecPos), .succPos(retSuccPos));

  rc_cover #(.BLK_W(BLK_W), .PREC_N(PREC_N), .SUCC_N(SUCC_N)) uQryPlace (
    .valid(regionOpen), .trig(curTrig), .precBits(curPrec), .succBits(curSucc),
    .blk(qryBlk), .inWin(unusedQryWin), .hit(qryHitS),
    .precPos(unusedQryPrec), .succPos(unusedQrySucc));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regionOpen <= 1'b0;
      curTrig    <= '0;
      curPrec    <= '0;
      curSucc    <= '0;
    end else if (strb.openFirst || strb.rollRegion) begin
      regionOpen <= 1'b1;
      curTrig    <= retBlk;
      curPrec    <= '0;
      curSucc    <= '0;
    end else if (strb.setBit) begin
      curPrec <= curPrec | retPrecPos;
      curSucc <= curSucc | retSuccPos;
    end
  end

  p_roll_trigger_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.rollRegion |=> (curTrig == $past(retBlk)) && (curPrec == '0) && (curSucc == '0));

  p_bits_grow_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.setBit |=> $stable(curTrig) && ((curPrec & $past(curPrec)) == $past(curPrec))
                    && ((curSucc & $past(curSucc)) == $past(curSucc)));
endmodule

// File: rtl/rc_temporal.sv
// Recency store of closed records plus the output register
module rc_temporal
  import rc_pkg::*;
#(
  parameter int BLK_W  = 26,
  parameter int PREC_N = 4,
  parameter int SUCC_N = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  rcStrobe_t         strb,
  input  logic [BLK_W-1:0]  inTrig,
  input  logic [PREC_N-1:0] inPrec,
  input  logic [SUCC_N-1:0] inSucc,
  input  logic [BLK_W-1:0]  qryBlk,
  output logic              tempMatch,
  output logic              outValid,
  output logic [BLK_W-1:0]  outTrig,
  output logic [PREC_N-1:0] outPrec,
  output logic [SUCC_N-1:0] outSucc,
  output logic              qryHitT
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  typedef struct packed {
    logic              v;
    logic [BLK_W-1:0]  t;
    logic [PREC_N-1:0] p;
    logic [SUCC_N-1:0] s;
  } entry_t;

  entry_t ent [DEPTH];
  entry_t nxt [DEPTH];
  logic [DEPTH-1:0] matchVec, qryVec;
  logic [IDX_W-1:0] matchIdx, posSel;
  logic unusedStrb;

  assign unusedStrb = strb.openFirst ^ strb.setBit ^ strb.rollRegion;

  for (genvar g = 0; g < DEPTH; g++) begin : gEntry
    logic              unusedWin;
    logic [PREC_N-1:0] unusedPrecPos;
    logic [SUCC_N-1:0] unusedSuccPos;
    assign matchVec[g] = ent[g].v && (ent[g].t == inTrig) &&
                         (ent[g].p == inPrec) && (ent[g].s == inSucc);
    rc_cover #(.BLK_W(BLK_W), .PREC_N(PREC_N), .SUCC_N(SUCC_N)) uQry (
      .valid(ent[g].v), .trig(ent[g].t), .precBits(ent[g].p), .succBits(ent[g].s),
      .blk(qryBlk), .inWin(unusedWin), .hit(qryVec[g]),
      .precPos(unusedPrecPos), .succPos(unusedSuccPos));
  end

  assign tempMatch = |matchVec;
  assign qryHitT   = |qryVec;

  always_comb begin
    matchIdx = '0;
    for (int i = 0; i < DEPTH; i++) if (matchVec[i]) matchIdx = IDX_W'(i);
    posSel = tempMatch ? matchIdx : IDX_W'(DEPTH - 1);
    for (int i = 0; i < DEPTH; i++) nxt[i] = ent[i];
    if (strb.promote || strb.insert) begin
      for (int i = DEPTH - 1; i > 0; i--)
        if (IDX_W'(i) <= posSel) nxt[i] = ent[i - 1];
      nxt[0] = '{v: 1'b1, t: inTrig, p: inPrec, s: inSucc};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
      outValid <= 1'b0;
      outTrig  <= '0;
      outPrec  <= '0;
      outSucc  <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) ent[i] <= nxt[i];
      if (strb.insert) begin
        outValid <= 1'b1;
        outTrig  <= inTrig;
        outPrec  <= inPrec;
        outSucc  <= inSucc;
      end else if (strb.popOut) begin
        outValid <= 1'b0;
      end
    end
  end

  p_unique_entries_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(matchVec));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !strb.popOut |=> outValid && $stable(outTrig) && $stable(outPrec) && $stable(outSucc));

  p_promote_silent_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.promote |=> !outValid);

  p_insert_emit_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.insert |=> outValid && (outTrig == $past(inTrig)) && (outPrec == $past(inPrec))
                    && (outSucc == $past(inSucc)));
endmodule

// File: rtl/region_compactor.sv
module region_compactor
  import rc_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int BLK_LOG = 6,
  parameter int PREC_N  = 4,
  parameter int SUCC_N  = 8,
  parameter int DEPTH   = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      retValid,
  input  logic [ADDR_W-1:0]         retAddr,
  output logic                      retReady,
  input  logic [ADDR_W-1:0]         qryAddr,
  output logic                      qryHit,
  output logic                      outValid,
  input  logic                      outReady,
  output logic [ADDR_W-BLK_LOG-1:0] outTrigger,
  output logic [PREC_N-1:0]         outPrec,
  output logic [SUCC_N-1:0]         outSucc
);
  localparam int BLK_W = ADDR_W - BLK_LOG;

  rcStrobe_t strb;
  logic [BLK_W-1:0]  retBlk, qryBlk, curTrig;
  logic [PREC_N-1:0] curPrec;
  logic [SUCC_N-1:0] curSucc;
  logic regionOpen, inRegion, tempMatch, qryHitS, qryHitT;
  logic unusedLowBits;

  assign retBlk        = retAddr[ADDR_W-1:BLK_LOG];
  assign qryBlk        = qryAddr[ADDR_W-1:BLK_LOG];
  assign unusedLowBits = ^{retAddr[BLK_LOG-1:0], qryAddr[BLK_LOG-1:0]};
  assign qryHit        = qryHitS || qryHitT;

  rc_ctrl uCtrl (
    .retValid(retValid), .outReady(outReady), .regionOpen(regionOpen),
    .inRegion(inRegion), .tempMatch(tempMatch), .outValid(outValid),
    .retReady(retReady), .strb(strb));

  rc_spatial #(.BLK_W(BLK_W), .PREC_N(PREC_N), .SUCC_N(SUCC_N)) uSpatial (
    .clk(clk), .rstN(rstN), .strb(strb), .retBlk(retBlk), .qryBlk(qryBlk),
    .regionOpen(regionOpen), .inRegion(inRegion), .curTrig(curTrig),
    .curPrec(curPrec), .curSucc(curSucc), .qryHitS(qryHitS));

  rc_temporal #(.BLK_W(BLK_W), .PREC_N(PREC_N), .SUCC_N(SUCC_N), .DEPTH(DEPTH)) uTemporal (
    .clk(clk), .rstN(rstN), .strb(strb), .inTrig(curTrig), .inPrec(curPrec),
    .inSucc(curSucc), .qryBlk(qryBlk), .tempMatch(tempMatch), .outValid(outValid),
    .outTrig(outTrigger), .outPrec(outPrec), .outSucc(outSucc), .qryHitT(qryHitT));

  p_first_silent_r2: assert property (@(posedge clk) disable iff (!rstN)
    !regionOpen |-> !outValid);
endmodule

// File: tb/sim_region_compactor.sv
module sim_region_compactor;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int BL = 6;
  localparam int P  = 4;
  localparam int S  = 8;
  localparam int D  = 4;
  localparam int BW = AW - BL;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic retValid = 1'b0, outReady = 1'b0;
  logic [AW-1:0] retAddr = '0, qryAddr = '0;
  logic retReady, qryHit, outValid;
  logic [BW-1:0] outTrigger;
  logic [P-1:0] outPrec;
  logic [S-1:0] outSucc;

  int nChk = 0, nBad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  region_compactor #(.ADDR_W(AW), .BLK_LOG(BL), .PREC_N(P), .SUCC_N(S), .DEPTH(D)) u0 (
    .clk(clk), .rstN(rstN), .retValid(retValid), .retAddr(retAddr), .retReady(retReady),
    .qryAddr(qryAddr), .qryHit(qryHit), .outValid(outValid), .outReady(outReady),
    .outTrigger(outTrigger), .outPrec(outPrec), .outSucc(outSucc));

  // reference model state
  logic mOpen, oV;
  logic [BW-1:0] mT, oT;
  logic [P-1:0] mP, oP;
  logic [S-1:0] mS, oS;
  logic tV [D];
  logic [BW-1:0] tT [D];
  logic [P-1:0] tP [D];
  logic [S-1:0] tS [D];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic mcov(logic [BW-1:0] t, logic [P-1:0] p, logic [S-1:0] s, logic [BW-1:0] b);
    logic [BW-1:0] f = b - t;
    logic [BW-1:0] k = t - b;
    if (f == '0) return 1'b1;
    for (int i = 0; i < P; i++) if (k == BW'(i + 1)) return p[i];
    for (int i = 0; i < S; i++) if (f == BW'(i + 1)) return s[i];
    return 1'b0;
  endfunction

  function automatic logic mwin(logic [BW-1:0] t, logic [BW-1:0] b);
    return mcov(t, '1, '1, b);
  endfunction

  function automatic logic expQ(logic [AW-1:0] q);
    logic h = mOpen && mcov(mT, mP, mS, q[AW-1:BL]);
    for (int i = 0; i < D; i++) if (tV[i] && mcov(tT[i], tP[i], tS[i], q[AW-1:BL])) h = 1'b1;
    return h;
  endfunction

  task automatic modelReset();
    mOpen = 0; oV = 0; mT = '0; mP = '0; mS = '0; oT = '0; oP = '0; oS = '0;
    for (int i = 0; i < D; i++) begin tV[i] = 0; tT[i] = '0; tP[i] = '0; tS[i] = '0; end
  endtask

  task automatic modelStep(input logic v, input logic [AW-1:0] a, input logic r);
    logic fire = v && (!oV || r);
    logic [BW-1:0] b = a[AW-1:BL];
    int k = -1;
    if (oV && r) oV = 0;
    if (!fire) return;
    if (!mOpen) begin
      mOpen = 1; mT = b; mP = '0; mS = '0;
    end else if (mwin(mT, b)) begin
      for (int i = 0; i < P; i++) if (mT - b == BW'(i + 1)) mP[i] = 1'b1;
      for (int i = 0; i < S; i++) if (b - mT == BW'(i + 1)) mS[i] = 1'b1;
    end else begin
      for (int i = 0; i < D; i++) if (tV[i] && tT[i] == mT && tP[i] == mP && tS[i] == mS) k = i;
      if (k < 0) begin
        k = D - 1;
        oV = 1; oT = mT; oP = mP; oS = mS;
      end
      for (int j = k; j > 0; j--) begin
        tV[j] = tV[j-1]; tT[j] = tT[j-1]; tP[j] = tP[j-1]; tS[j] = tS[j-1];
      end
      tV[0] = 1; tT[0] = mT; tP[0] = mP; tS[0] = mS;
      mT = b; mP = '0; mS = '0;
    end
  endtask

  // one clock: check outputs against the model, then apply the edge
  task automatic step(input logic v, input logic [AW-1:0] a, input logic r, input logic [AW-1:0] q);
    retValid = v; retAddr = a; outReady = r; qryAddr = q;
    #1;
    chk("R7 retReady", retReady, !oV || r);
    chk("R8 qryHit", qryHit, expQ(q));
    chk("R6 outValid", outValid, oV);
    if (oV) begin
      chk("R6 outTrigger", outTrigger, oT);
      chk("R6 outPrec", outPrec, oP);
      chk("R6 outSucc", outSucc, oS);
    end
    modelStep(v, a, r);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic probe(input logic [AW-1:0] q, input logic r, input string tag, input logic expHit);
    retValid = 0; outReady = r; qryAddr = q;
    #1;
    chk(tag, qryHit, expHit);
  endtask

  initial begin
    automatic logic [AW-1:0] bases[4] = '{32'h0001_0000, 32'h0001_0800, 32'h0004_0000, 32'h0004_0200};
    automatic logic [AW-1:0] loopProg[7] = '{32'h3000, 32'h3040, 32'h2F80, 32'h3400,
                                             32'h3440, 32'h33C0, 32'h5000};
    void'($urandom(32'h0C0FFEE1));
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    chk("R1 outValid", outValid, 0);
    chk("R1 retReady", retReady, 1);
    probe(32'h1000, 1, "R1 qryHit", 0);

    // R2: first retirement opens silently
    step(1, 32'h1000, 1, 0);
    chk("R2 outValid", outValid, 0);
    probe(32'h1000, 1, "R3 trigger counts", 1);
    probe(32'h1040, 1, "R3 unset ahead bit", 0);

    // R3: window edges -PREC and +SUCC
    step(1, 32'h1040, 1, 0);
    step(1, 32'h0F00, 1, 0);
    step(1, 32'h1200, 1, 0);
    probe(32'h1200, 1, "R3 ahead edge", 1);
    probe(32'h0F40, 1, "R3 unset behind bit", 0);
    probe(32'h0EC0, 1, "R3 beyond behind edge", 0);

    // R4: leaving the window closes and reopens
    step(1, 32'h1240, 0, 0);
    chk("R4 outValid", outValid, 1);
    chk("R4 outTrigger", outTrigger, 26'h40);
    chk("R4 outPrec", outPrec, 4'b1000);
    chk("R4 outSucc", outSucc, 8'h81);
    probe(32'h1240, 0, "R4 new trigger", 1);
    probe(32'h1040, 0, "R8 stored record", 1);
    step(0, 0, 0, 0);
    chk("R7 held outValid", outValid, 1);
    chk("R7 held outTrigger", outTrigger, 26'h40);
    chk("R7 retReady low", retReady, 0);
    step(0, 0, 1, 0);
    chk("R7 consumed", outValid, 0);

    // R5: same region again is filtered
    step(1, 32'h1000, 1, 0);
    chk("R6 new record", outTrigger, 26'h49);
    step(1, 32'h1040, 1, 0);
    step(1, 32'h0F00, 1, 0);
    step(1, 32'h1200, 1, 0);
    step(1, 32'h1240, 1, 0);
    chk("R5 no emission", outValid, 0);
    probe(32'h0F00, 1, "R5 still covered", 1);

    // R6: eviction of least recent entries
    step(1, 32'h10000, 1, 0);
    step(1, 32'h14000, 1, 0);
    step(1, 32'h18000, 1, 0);
    step(1, 32'h1C000, 1, 0);
    step(1, 32'h20000, 1, 0);
    step(0, 0, 1, 0);
    probe(32'h1040, 1, "R6 evicted", 0);

    // repeated loops to exercise promotion under backpressure
    for (int n = 0; n < 40; n++)
      for (int j = 0; j < 7; j++)
        step(($urandom % 8) != 0, loopProg[j], ($urandom % 4) != 0,
             loopProg[$urandom % 7] + 32'(($urandom % 5) * 64));

    // constrained random addresses near a few bases
    for (int n = 0; n < 3000; n++) begin
      automatic logic [AW-1:0] a = bases[$urandom % 4] + 32'((int'($urandom % 17) - 6) * 64);
      automatic logic [AW-1:0] q = bases[$urandom % 4] + 32'((int'($urandom % 17) - 6) * 64);
      step(($urandom % 5) != 0, a, ($urandom % 10) < 7, q);
    end
    step(0, 0, 1, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule